// File: doc/BRIEF.md
# SD Command-Line Response Capture

This block listens to the serial command line of an SD/MMC host while a response is expected. It takes one bit per clock and starts a frame on the first low bit. It collects either a short frame of 48 bits or a long frame of 136 bits. For every frame it checks the CRC7 and the end bit, and for short frames it can also check the returned command index.

When the frame ends, the useful payload is written into one slot of a shared 128-bit response register, and the bits outside that slot keep their value:
- A normal short response fills the low word.
- A response to an automatically issued stop command fills the top word. This way it never overwrites a normal response that arrived alongside it.
- A long identification or card-specific response fills the low 120 bits.

The payload is stored even when a check fails. A one-cycle completion pulse marks the end of the frame. The error flags stay valid until the next frame begins.

The controller arms the block once per expected response. When arming, it gives the response kind, the stop-command flag, the check enables and the expected index. It then reads `resp_reg` and the flags after `done`.

Top module: `sd_resp_capture`

## Requirements
- R1: When `arm` is high in a cycle where the block is idle and `resp_kind` is not 00, the block starts waiting for a response, and `busy` reads 1 from the next cycle until the frame completes. The `resp_kind` encoding is 00 none, 01 short, 10 short with busy, 11 long. `arm` with kind 00, or `arm` while `busy` is high, has no effect.
- R2: While waiting, high levels on `cmd_in` are skipped. The first low level is taken as the start bit R[47] (short) or R[135] (long), and exactly 48 or 136 bits are then counted. While idle, `cmd_in` has no effect.
- R3: A short frame without the stop flag writes R[39:8] into `resp_reg[31:0]` and leaves `resp_reg[127:32]` unchanged.
- R4: A short frame with `auto_stop` set writes R[39:8] into `resp_reg[127:96]` and leaves `resp_reg[95:0]` unchanged.
- R5: A long frame writes R[127:8] into `resp_reg[119:0]` and leaves `resp_reg[127:120]` unchanged, whatever the value of `auto_stop`.
- R6: The CRC7 uses the polynomial x^7+x^3+1, a zero initial value, and most significant bit first. It is computed over R[47:8] (short) or R[127:8] (long) and compared with R[7:1]. On a mismatch, `err_crc` is set when `crc_chk_en` was high at arming, and stays clear otherwise.
- R7: For short frames, when `idx_chk_en` was set at arming, `err_idx` is set if R[45:40] differs from `exp_index`. For long frames, `err_idx` is never set.
- R8: `err_end` is set when the last bit R[0] is 0.
- R9: `done` is high for exactly one cycle, the cycle after the last bit is sampled. `resp_reg` and the flags take their new values in that same cycle. `resp_reg` changes at no other time.
- R10: The error flags hold their value until the start bit of the next frame, and are cleared in the cycle after that start bit.
- R11: Kind 10 (short with busy) captures and checks exactly like kind 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one command-line bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Begin waiting for a response |
| resp_kind | input | 2 | Response kind: 00 none, 01 short, 10 short with busy, 11 long |
| auto_stop | input | 1 | Response belongs to an automatic stop command |
| idx_chk_en | input | 1 | Enable the command index check |
| crc_chk_en | input | 1 | Enable the CRC7 check |
| exp_index | input | 6 | Expected command index |
| cmd_in | input | 1 | Serial command line |
| busy | output | 1 | Waiting for or receiving a response |
| done | output | 1 | One-cycle completion pulse |
| err_crc | output | 1 | CRC7 mismatch |
| err_idx | output | 1 | Command index mismatch |
| err_end | output | 1 | End bit was zero |
| resp_reg | output | 128 | Response register read port |

## Verification
The assertions assume that `cmd_in` carries exactly one bit per clock and that a frame runs to its full length once it has started. This means the one-cycle pulse of `done` and the slot-keeping properties rely on frames being at least two cycles apart. The stimulus arms only with valid configuration, drives complete frames at the falling edge, and inserts idle-high cycles between frames. It also drives low levels on `cmd_in` and extra `arm` pulses only in the windows where R1 and R2 say they must be ignored.

// File: rtl/sd_resp_pkg.sv
package sd_resp_pkg;
   typedef enum logic [1:0] {
      RK_NONE       = 2'b00,
      RK_SHORT      = 2'b01,
      RK_SHORT_BUSY = 2'b10,
      RK_LONG       = 2'b11
   } resp_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_WAIT  = 2'b01,
      ST_SHIFT = 2'b10
   } cap_state_e;
endpackage

// File: rtl/sd_crc7_serial.sv
module sd_crc7_serial #(
   parameter int CRC_W = 7,
   parameter logic [CRC_W-1:0] POLY = 7'h09
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic             din,
   output logic [CRC_W-1:0] crc
);
   generate
      if (CRC_W < 2) begin : g_bad_width
         $error("sd_crc7_serial: CRC_W must be at least 2");
      end
   endgenerate

   logic             fb;
   logic [CRC_W-1:0] crc_shift;

   assign fb        = crc[CRC_W-1] ^ din;
   assign crc_shift = {crc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc <= '0;
      else if (clr) crc <= '0;
      else if (en)  crc <= crc_shift;
   end
endmodule

// File: rtl/sd_resp_slot.sv
module sd_resp_slot #(
   parameter int REG_W      = 128,
   parameter int SH_W       = 135,
   parameter int PAY_LSB    = 7,
   parameter int SHORT_PAY  = 32,
   parameter int LONG_PAY   = 120,
   parameter int AUTO_LO    = 96
) (
   input  logic [REG_W-1:0] cur,
   input  logic [SH_W-1:0]  frame_bits,
   input  logic             is_long,
   input  logic             is_auto,
   output logic [REG_W-1:0] nxt
);
   generate
      if (AUTO_LO + SHORT_PAY > REG_W) begin : g_bad_auto
         $error("sd_resp_slot: stop-command slot exceeds register");
      end
      if (LONG_PAY > REG_W) begin : g_bad_long
         $error("sd_resp_slot: long payload exceeds register");
      end
      if (PAY_LSB + LONG_PAY > SH_W) begin : g_bad_shreg
         $error("sd_resp_slot: shift register too narrow");
      end
   endgenerate

   logic [SHORT_PAY-1:0] short_pay;
   logic [LONG_PAY-1:0]  long_pay;

   assign short_pay = frame_bits[PAY_LSB +: SHORT_PAY];
   assign long_pay  = frame_bits[PAY_LSB +: LONG_PAY];

   always_comb begin
      nxt = cur;
      if (is_long)      nxt[LONG_PAY-1:0]             = long_pay;
      else if (is_auto) nxt[AUTO_LO +: SHORT_PAY]     = short_pay;
      else              nxt[SHORT_PAY-1:0]            = short_pay;
   end
endmodule

// File: rtl/sd_resp_capture.sv
module sd_resp_capture
   import sd_resp_pkg::*;
#(
   parameter int SHORT_LEN = 48,
   parameter int LONG_LEN  = 136,
   parameter int REG_W     = 128,
   parameter int IDX_W     = 6,
   parameter int CRC_W     = 7,
   parameter int PAY_W     = 32,
   parameter int AUTO_LO   = 96,
   parameter logic [CRC_W-1:0] CRC_POLY = 7'h09
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic [1:0]       resp_kind,
   input  logic             auto_stop,
   input  logic             idx_chk_en,
   input  logic             crc_chk_en,
   input  logic [IDX_W-1:0] exp_index,
   input  logic             cmd_in,
   output logic             busy,
   output logic             done,
   output logic             err_crc,
   output logic             err_idx,
   output logic             err_end,
   output logic [REG_W-1:0] resp_reg
);
   localparam int SH_W      = LONG_LEN - 1;
   localparam int CNT_W     = $clog2(LONG_LEN);
   localparam int HDR_W     = 8;
   localparam int LONG_PAY  = LONG_LEN - HDR_W - CRC_W - 1;
   localparam int PAY_LSB   = CRC_W;
   localparam int IDX_LSB   = CRC_W + PAY_W;
   localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_LEN - 1);
   localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_LEN - 1);
   localparam logic [CNT_W-1:0] SHORT_TOP  = CNT_W'(SHORT_LEN - 2);
   localparam logic [CNT_W-1:0] LONG_TOP   = CNT_W'(LONG_LEN - HDR_W - 1);
   localparam logic [CNT_W-1:0] CRC_LOW    = CNT_W'(CRC_W + 1);

   generate
      if (SHORT_LEN != 2 + IDX_W + PAY_W + CRC_W + 1) begin : g_bad_short
         $error("sd_resp_capture: short frame layout inconsistent");
      end
      if (LONG_LEN <= SHORT_LEN) begin : g_bad_long
         $error("sd_resp_capture: long frame must exceed short frame");
      end
   endgenerate

   cap_state_e       state_q;
   resp_kind_e       kind_q;
   logic             auto_q, idxen_q, crcen_q;
   logic [IDX_W-1:0] expidx_q;
   logic [CNT_W-1:0] cnt_q;
   logic [SH_W-1:0]  shreg_q;
   logic [CRC_W-1:0] crc_val;
   logic [REG_W-1:0] slot_nxt;

   logic             arm_ok, start_evt, long_q, fin, crc_step;
   logic [CNT_W-1:0] last_cnt, bit_idx, crc_top;

   assign arm_ok    = (state_q == ST_IDLE) && arm && (resp_kind != RK_NONE);
   assign start_evt = (state_q == ST_WAIT) && !cmd_in;
   assign long_q    = (kind_q == RK_LONG);
   assign last_cnt  = long_q ? LONG_LAST : SHORT_LAST;
   assign crc_top   = long_q ? LONG_TOP : SHORT_TOP;
   assign bit_idx   = last_cnt - cnt_q;
   assign fin       = (state_q == ST_SHIFT) && (cnt_q == last_cnt);
   assign crc_step  = (state_q == ST_SHIFT) && (bit_idx >= CRC_LOW) && (bit_idx <= crc_top);
   assign busy      = (state_q != ST_IDLE);

   sd_crc7_serial #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (start_evt),
      .en   (crc_step),
      .din  (cmd_in),
      .crc  (crc_val)
   );

   sd_resp_slot #(
      .REG_W(REG_W), .SH_W(SH_W), .PAY_LSB(PAY_LSB),
      .SHORT_PAY(PAY_W), .LONG_PAY(LONG_PAY), .AUTO_LO(AUTO_LO)
   ) u_slot (
      .cur       (resp_reg),
      .frame_bits(shreg_q),
      .is_long   (long_q),
      .is_auto   (auto_q),
      .nxt       (slot_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         kind_q   <= RK_NONE;
         auto_q   <= 1'b0;
         idxen_q  <= 1'b0;
         crcen_q  <= 1'b0;
         expidx_q <= '0;
         cnt_q    <= '0;
         shreg_q  <= '0;
         done     <= 1'b0;
         err_crc  <= 1'b0;
         err_idx  <= 1'b0;
         err_end  <= 1'b0;
         resp_reg <= '0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (arm_ok) begin
               kind_q   <= resp_kind_e'(resp_kind);
               auto_q   <= auto_stop;
               idxen_q  <= idx_chk_en;
               crcen_q  <= crc_chk_en;
               expidx_q <= exp_index;
               state_q  <= ST_WAIT;
            end
            ST_WAIT: if (start_evt) begin
               state_q <= ST_SHIFT;
               cnt_q   <= CNT_W'(1);
               shreg_q <= {shreg_q[SH_W-2:0], cmd_in};
               err_crc <= 1'b0;
               err_idx <= 1'b0;
               err_end <= 1'b0;
            end
            ST_SHIFT: begin
               shreg_q <= {shreg_q[SH_W-2:0], cmd_in};
               cnt_q   <= cnt_q + CNT_W'(1);
               if (fin) begin
                  state_q  <= ST_IDLE;
                  done     <= 1'b1;
                  resp_reg <= slot_nxt;
                  err_end  <= !cmd_in;
                  err_crc  <= crcen_q && (crc_val != shreg_q[CRC_W-1:0]);
                  err_idx  <= idxen_q && !long_q &&
                              (shreg_q[IDX_LSB +: IDX_W] != expidx_q);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // Guards on capture timing and slot integrity
   assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !arm) |=> (state_q == ST_IDLE));
   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_reg_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !fin |=> $stable(resp_reg));
   assert_short_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && !long_q && !auto_q) |=> (resp_reg[REG_W-1:PAY_W] == $past(resp_reg[REG_W-1:PAY_W])));
   assert_auto_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && !long_q && auto_q) |=> (resp_reg[AUTO_LO-1:0] == $past(resp_reg[AUTO_LO-1:0])));
   assert_long_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && long_q) |=> (resp_reg[REG_W-1:LONG_PAY] == $past(resp_reg[REG_W-1:LONG_PAY])));
   assert_long_no_idx_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && long_q) |=> !err_idx);
   assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_evt && !fin) |=> ($stable(err_crc) && $stable(err_idx) && $stable(err_end)));
   assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SHIFT) |-> (cnt_q <= last_cnt));
endmodule

// File: tb/sd_resp_capture_test.sv
module sd_resp_capture_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         arm = 1'b0;
   logic [1:0]   resp_kind = 2'b00;
   logic         auto_stop = 1'b0;
   logic         idx_chk_en = 1'b0;
   logic         crc_chk_en = 1'b0;
   logic [5:0]   exp_index = 6'd0;
   logic         cmd_in = 1'b1;
   logic         busy, done, err_crc, err_idx, err_end;
   logic [127:0] resp_reg;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   // expected values at the next falling edge
   logic [127:0] e_reg  = '0;
   logic         e_done = 1'b0;
   logic         e_busy = 1'b0;
   logic         e_crc = 1'b0, e_idx = 1'b0, e_end = 1'b0;

   always #10 clk = ~clk;

   sd_resp_capture uut (
      .clk(clk), .rst_n(rst_n), .arm(arm), .resp_kind(resp_kind),
      .auto_stop(auto_stop), .idx_chk_en(idx_chk_en), .crc_chk_en(crc_chk_en),
      .exp_index(exp_index), .cmd_in(cmd_in), .busy(busy), .done(done),
      .err_crc(err_crc), .err_idx(err_idx), .err_end(err_end), .resp_reg(resp_reg)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic tick(input string req);
      @(negedge clk);
      check(done === e_done, req, "done", {127'd0, done}, {127'd0, e_done});
      check(busy === e_busy, req, "busy", {127'd0, busy}, {127'd0, e_busy});
      check(resp_reg === e_reg, req, "resp_reg", resp_reg, e_reg);
      check({err_crc, err_idx, err_end} === {e_crc, e_idx, e_end}, req, "flags",
            {125'd0, err_crc, err_idx, err_end}, {125'd0, e_crc, e_idx, e_end});
      e_done = 1'b0;
   endtask

   function automatic logic [6:0] ref_crc(input logic [135:0] f, input int hi);
      logic [6:0] c = '0;
      for (int i = hi; i >= 8; i--) begin
         logic fb = c[6] ^ f[i];
         c = {c[5:0], 1'b0};
         if (fb) c = c ^ 7'h09;
      end
      return c;
   endfunction

   function automatic logic [135:0] mk_short(input logic [5:0] idx, input logic [31:0] arg,
                                             input bit bad_crc, input bit bad_end);
      logic [135:0] f = '0;
      f[45:40] = idx;
      f[39:8]  = arg;
      f[7:1]   = ref_crc(f, 47) ^ (bad_crc ? 7'h01 : 7'h00);
      f[0]     = !bad_end;
      return f;
   endfunction

   function automatic logic [135:0] mk_long(input logic [119:0] pay, input bit bad_crc);
      logic [135:0] f = '0;
      f[133:128] = 6'h3F;
      f[127:8]   = pay;
      f[7:1]     = ref_crc(f, 127) ^ (bad_crc ? 7'h40 : 7'h00);
      f[0]       = 1'b1;
      return f;
   endfunction

   task automatic send(input logic [1:0] kind, input bit auto, input bit ien, input bit cen,
                       input logic [5:0] xidx, input logic [135:0] f, input int idle,
                       input bit mid_arm, input string req);
      int len = (kind == 2'b11) ? 136 : 48;
      arm = 1'b1; resp_kind = kind; auto_stop = auto;
      idx_chk_en = ien; crc_chk_en = cen; exp_index = xidx;
      e_busy = 1'b1;
      tick(req);
      arm = 1'b0;
      resp_kind = 2'b00; auto_stop = 1'b0; idx_chk_en = 1'b0; crc_chk_en = 1'b0; exp_index = 6'd0;
      for (int k = 0; k < idle; k++) begin
         cmd_in = 1'b1;
         tick(req);
      end
      for (int i = len - 1; i >= 0; i--) begin
         cmd_in = f[i];
         arm = (mid_arm && i == len - 5);
         resp_kind = arm ? 2'b01 : 2'b00;
         auto_stop = arm;
         if (i == len - 1) begin
            e_crc = 1'b0; e_idx = 1'b0; e_end = 1'b0;
         end
         if (i == 0) begin
            if (kind == 2'b11) e_reg[119:0] = f[127:8];
            else if (auto)     e_reg[127:96] = f[39:8];
            else               e_reg[31:0] = f[39:8];
            e_crc  = cen && (ref_crc(f, len == 136 ? 127 : 47) != f[7:1]);
            e_idx  = ien && (kind != 2'b11) && (f[45:40] != xidx);
            e_end  = !f[0];
            e_done = 1'b1;
            e_busy = 1'b0;
         end
         tick(req);
      end
      arm = 1'b0; resp_kind = 2'b00; auto_stop = 1'b0;
      cmd_in = 1'b1;
      tick(req);
      tick(req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick("R9");  // reset state
      // R3: normal short response into the low word
      send(2'b01, 0, 1, 1, 6'd17, mk_short(6'd17, 32'hA5A5_1234, 0, 0), 3, 0, "R3");
      // R4: stop-command response into the top word, low word preserved
      send(2'b01, 1, 1, 1, 6'd12, mk_short(6'd12, 32'hC0DE_F00D, 0, 0), 0, 0, "R4");
      // R5: long response, top byte of stop slot preserved, auto flag ignored
      send(2'b11, 1, 1, 1, 6'd2,
           mk_long(120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32, 0), 5, 0, "R5");
      // R11: short with busy behaves like short
      send(2'b10, 0, 1, 1, 6'd7, mk_short(6'd7, 32'h1357_9BDF, 0, 0), 2, 0, "R11");
      // R6: bad CRC with check enabled, then disabled
      send(2'b01, 0, 0, 1, 6'd3, mk_short(6'd3, 32'h0000_FFFF, 1, 0), 1, 0, "R6");
      send(2'b01, 0, 0, 0, 6'd3, mk_short(6'd3, 32'hFFFF_0000, 1, 0), 1, 0, "R6");
      send(2'b11, 0, 0, 1, 6'd0, mk_long(120'h5A5A_5A5A_0F0F_0F0F_AAAA_5555_FFFF_00, 1), 1, 0, "R6");
      // R7: index mismatch enabled / disabled, long never flags
      send(2'b01, 0, 1, 0, 6'd9, mk_short(6'd8, 32'h2468_ACE0, 0, 0), 1, 0, "R7");
      send(2'b01, 0, 0, 0, 6'd9, mk_short(6'd8, 32'h2468_ACE1, 0, 0), 1, 0, "R7");
      send(2'b11, 0, 1, 1, 6'd9, mk_long(120'h1, 0), 1, 0, "R7");
      // R8: end bit zero
      send(2'b01, 0, 1, 1, 6'd5, mk_short(6'd5, 32'h8000_0001, 0, 1), 1, 0, "R8");
      // R10: flags hold through idle cycles until the next start bit
      for (int k = 0; k < 6; k++) tick("R10");
      send(2'b01, 0, 1, 1, 6'd5, mk_short(6'd5, 32'h7777_8888, 0, 0), 4, 0, "R10");
      // R1: arm with kind none is ignored, even with a low line (R2)
      arm = 1'b1; resp_kind = 2'b00;
      tick("R1");
      arm = 1'b0; cmd_in = 1'b0;
      for (int k = 0; k < 60; k++) tick("R2");
      cmd_in = 1'b1;
      tick("R2");
      // R1: arm during capture is ignored
      send(2'b01, 0, 1, 1, 6'd33, mk_short(6'd33, 32'hDEAD_BEEF, 0, 0), 2, 1, "R1");
      // R2: long run of idle ones before the start bit
      send(2'b11, 0, 0, 1, 6'd0, mk_long(120'hFEED_0000_1111_2222_3333_4444_5555_66, 0), 40, 0, "R2");
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule